// File: doc/BRIEF.md
# Synthesizer Control Register Front End

This block is the programming front end of an integer-N frequency synthesizer. It takes the slow control pins that set up the synthesizer. It turns them into registered divider settings: a 9-bit main counter value, a 6-bit reference counter value and a 4-bit swallow counter value, plus a prescaler-bypass bit. It also produces a group of six auxiliary control bits. The dividers, prescaler, phase detector and loop filter sit elsewhere.

Two programming modes exist, chosen by a static mode pin.

- **Serial mode (mode pin low).** A serial data line is sampled on each rising edge of a serial clock. A single 20-bit shift buffer collects these bits.
  - A rising edge on the frequency strobe copies the buffer into the frequency register. This happens only while the auxiliary strobe is low.
  - While the auxiliary strobe is high, the falling edge of that strobe copies the last eight shifted bits into the auxiliary register.
- **Direct mode (mode pin high).** The counter values come from parallel pins, and prescaler bypass is held off.

All serial pins are synchronized into the system clock domain and edge-detected there. The auxiliary outputs are masked to zero unless an active-low enable pin is low.

Top module: `synth_ctl`

## Requirements
- R1: A synchronous reset clears the shift buffer, both registers and every output to zero.
- R2: In serial mode, the frequency word loads as follows.
  - Each rising serial-clock edge shifts one data bit in. Twenty bits B0..B19 are sent, B0 first.
  - A frequency-strobe rising edge while the auxiliary strobe is low commits the word.
  - Bit assignment: B0=ref[5], B1=ref[4], B2=main[8], B3=main[7], B4=bypass, B5..B11=main[6:0] (main[6] first), B12..B15=ref[3:0] (ref[3] first), B16..B19=swallow[3:0] (swallow[3] first).
- R3: A frequency-strobe rising edge while the auxiliary strobe is high leaves the frequency register unchanged.
- R4: The auxiliary word loads as follows.
  - Eight bits B0..B7 are shifted while the auxiliary strobe is high, and its falling edge commits them.
  - Bit assignment: B1=fp_en, B2=pwr_dn, B3=cnt_load, B4=msel_en, B5=fc_en, B6=enh_bypass. B0 and B7 are reserved and drive nothing.
  - An auxiliary write leaves the frequency register unchanged.
- R5: While enh_n is high, all six auxiliary outputs read 0. When enh_n returns low, the stored auxiliary values reappear.
- R6: When more bits than the target length are shifted before a commit, only the last 20 (frequency) or last 8 (auxiliary) bits are used.
- R7: In direct mode, the counter outputs follow dir_m, dir_r and dir_a, and pb_out is 0 whatever the frequency register holds.
- R8: In direct mode, a frequency-strobe edge does not change the frequency register. On return to serial mode, the outputs show the last serially committed word.
- R9: Data-line changes while the serial clock is steady shift nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| dmode | input | 1 | 0 = serial programming, 1 = direct pins |
| sdata | input | 1 | Serial data line |
| sclk | input | 1 | Serial clock, sampled on rising edges |
| s_wr | input | 1 | Frequency strobe, commits on rising edge |
| e_wr | input | 1 | Auxiliary strobe, high during auxiliary shift, commits on falling edge |
| enh_n | input | 1 | Active-low enable for auxiliary outputs |
| dir_m | input | 9 | Direct-mode main counter value |
| dir_r | input | 6 | Direct-mode reference counter value |
| dir_a | input | 4 | Direct-mode swallow counter value |
| m_cnt | output | 9 | Main counter value |
| r_cnt | output | 6 | Reference counter value |
| a_cnt | output | 4 | Swallow counter value |
| pb_out | output | 1 | Prescaler bypass from the frequency word |
| fp_en | output | 1 | Phase-detector output enable |
| pwr_dn | output | 1 | Power-down request |
| cnt_load | output | 1 | Counter load request |
| msel_en | output | 1 | Modulus-select output enable |
| fc_en | output | 1 | Reference-divider output enable |
| enh_bypass | output | 1 | Auxiliary prescaler-bypass control |

## Verification
The frequency path is tried with three kinds of word:

- Arithmetic sweeps over all swallow values with spread main and reference values.
- A walking one over all twenty bit positions, which pins down the field layout bit by bit.
- Over-length and glitching streams, which show that only the final window and only clock edges count.

The auxiliary path is swept over all 256 byte values. This separates each control bit from the reserved ones, and the enable pin is toggled during the sweep. Direct mode is swept over pin combinations with a bypass-set serial word held in the register. That shows that the forcing and the preservation of the serial value are separate effects.

// File: rtl/synth_ctl_pkg.sv
package synth_ctl_pkg;

  localparam int M_W         = 9;
  localparam int R_W         = 6;
  localparam int A_W         = 4;
  localparam int FREQ_W      = M_W + R_W + A_W + 1;
  localparam int ENH_W       = 8;
  localparam int ENH_PAY_W   = ENH_W - 2;
  localparam int SYNC_STAGES = 2;

  typedef struct packed {
    logic [M_W-1:0] m;
    logic [R_W-1:0] r;
    logic [A_W-1:0] a;
    logic           pb;
  } freq_t;

  typedef struct packed {
    logic bypass;
    logic fc;
    logic msel;
    logic cnt_load;
    logic pwr_dn;
    logic fp;
  } enh_t;

  // Buffer index FREQ_W-1 holds the first bit shifted in.
  function automatic freq_t unpack_freq(input logic [FREQ_W-1:0] w);
    freq_t f;
    f.r  = {w[19], w[18], w[7:4]};
    f.m  = {w[17], w[16], w[14:8]};
    f.pb = w[15];
    f.a  = w[3:0];
    return f;
  endfunction

  // Payload excludes both reserved end bits; p[ENH_PAY_W-1] is the second bit shifted.
  function automatic enh_t unpack_enh(input logic [ENH_PAY_W-1:0] p);
    enh_t e;
    e.fp       = p[5];
    e.pwr_dn   = p[4];
    e.cnt_load = p[3];
    e.msel     = p[2];
    e.fc       = p[1];
    e.bypass   = p[0];
    return e;
  endfunction

endpackage

// File: rtl/sync_chain.sv
module sync_chain #(
  parameter int W      = 4,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [STAGES-1:0][W-1:0] st;

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= '0;
    end else begin
      st[0] <= d;
      for (int i = 1; i < STAGES; i++) begin
        st[i] <= st[i-1];
      end
    end
  end

  assign q = st[STAGES-1];

endmodule

// File: rtl/ser_shift.sv
module ser_shift #(
  parameter int W = 20
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         shift_en,
  input  logic         din,
  output logic [W-1:0] q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      q <= '0;
    end else if (shift_en) begin
      q <= {q[W-2:0], din};
    end
  end

  // R9
  shift_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !shift_en |=> $stable(q));

endmodule

// File: rtl/ctl_regs.sv
module ctl_regs
  import synth_ctl_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 dir_mode,
  input  logic                 enh_n,
  input  logic                 freq_commit,
  input  logic                 enh_commit,
  input  logic [FREQ_W-1:0]    freq_word,
  input  logic [ENH_PAY_W-1:0] enh_word,
  input  logic [M_W-1:0]       dir_m,
  input  logic [R_W-1:0]       dir_r,
  input  logic [A_W-1:0]       dir_a,
  output freq_t                out_f,
  output enh_t                 out_e
);

  freq_t freq_q;
  enh_t  enh_q;
  freq_t dir_sel;

  always_comb begin
    dir_sel.m  = dir_m;
    dir_sel.r  = dir_r;
    dir_sel.a  = dir_a;
    dir_sel.pb = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      freq_q <= '0;
    end else if (freq_commit) begin
      freq_q <= unpack_freq(freq_word);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      enh_q <= '0;
    end else if (enh_commit) begin
      enh_q <= unpack_enh(enh_word);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_f <= '0;
      out_e <= '0;
    end else begin
      out_f <= dir_mode ? dir_sel : freq_q;
      out_e <= enh_n ? '0 : enh_q;
    end
  end

  // R3
  freq_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !freq_commit |=> $stable(freq_q));

  // R4
  enh_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !enh_commit |=> $stable(enh_q));

  // R5
  enh_mask_chk: assert property (@(posedge clk) disable iff (rst)
    enh_n |=> (out_e == '0));

  // R7
  dir_nobypass_chk: assert property (@(posedge clk) disable iff (rst)
    dir_mode |=> !out_f.pb);

  // R8
  dir_keep_chk: assert property (@(posedge clk) disable iff (rst)
    dir_mode |=> $stable(freq_q));

endmodule

// File: rtl/synth_ctl.sv
module synth_ctl
  import synth_ctl_pkg::*;
#(
  parameter int SYNC_DEPTH = SYNC_STAGES
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           dmode,
  input  logic           sdata,
  input  logic           sclk,
  input  logic           s_wr,
  input  logic           e_wr,
  input  logic           enh_n,
  input  logic [M_W-1:0] dir_m,
  input  logic [R_W-1:0] dir_r,
  input  logic [A_W-1:0] dir_a,
  output logic [M_W-1:0] m_cnt,
  output logic [R_W-1:0] r_cnt,
  output logic [A_W-1:0] a_cnt,
  output logic           pb_out,
  output logic           fp_en,
  output logic           pwr_dn,
  output logic           cnt_load,
  output logic           msel_en,
  output logic           fc_en,
  output logic           enh_bypass
);

  localparam int PIN_W  = 4;
  localparam int EDGE_W = PIN_W - 1;

  logic [PIN_W-1:0]  sy;
  logic [EDGE_W-1:0] prv;
  logic              sclk_rise, swr_rise, ewr_fall;
  logic              freq_commit;
  logic [FREQ_W-1:0] sbuf;
  freq_t             of;
  enh_t              oe;

  sync_chain #(.W(PIN_W), .STAGES(SYNC_DEPTH)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({e_wr, s_wr, sclk, sdata}),
    .q   (sy)
  );

  always_ff @(posedge clk) begin
    if (rst) prv <= '0;
    else     prv <= sy[PIN_W-1:1];
  end

  assign sclk_rise   = sy[1] & ~prv[0];
  assign swr_rise    = sy[2] & ~prv[1];
  assign ewr_fall    = ~sy[3] & prv[2];
  assign freq_commit = swr_rise & ~sy[3] & ~dmode;

  ser_shift #(.W(FREQ_W)) u_shift (
    .clk      (clk),
    .rst      (rst),
    .shift_en (sclk_rise),
    .din      (sy[0]),
    .q        (sbuf)
  );

  ctl_regs u_regs (
    .clk         (clk),
    .rst         (rst),
    .dir_mode    (dmode),
    .enh_n       (enh_n),
    .freq_commit (freq_commit),
    .enh_commit  (ewr_fall),
    .freq_word   (sbuf),
    .enh_word    (sbuf[ENH_W-2:1]),
    .dir_m       (dir_m),
    .dir_r       (dir_r),
    .dir_a       (dir_a),
    .out_f       (of),
    .out_e       (oe)
  );

  assign m_cnt      = of.m;
  assign r_cnt      = of.r;
  assign a_cnt      = of.a;
  assign pb_out     = of.pb;
  assign fp_en      = oe.fp;
  assign pwr_dn     = oe.pwr_dn;
  assign cnt_load   = oe.cnt_load;
  assign msel_en    = oe.msel;
  assign fc_en      = oe.fc;
  assign enh_bypass = oe.bypass;

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (m_cnt == '0 && r_cnt == '0 && a_cnt == '0 && !pb_out &&
             !fp_en && !pwr_dn && !cnt_load && !msel_en && !fc_en && !enh_bypass));

endmodule

// File: tb/synth_ctl_bench.sv
module synth_ctl_bench;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic       rst = 1'b1, dmode = 1'b0, sdata = 1'b0, sclk = 1'b0;
  logic       s_wr = 1'b0, e_wr = 1'b0, enh_n = 1'b0;
  logic [8:0] dir_m = '0;
  logic [5:0] dir_r = '0;
  logic [3:0] dir_a = '0;
  logic [8:0] m_cnt;
  logic [5:0] r_cnt;
  logic [3:0] a_cnt;
  logic       pb_out, fp_en, pwr_dn, cnt_load, msel_en, fc_en, enh_bypass;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  synth_ctl u_synth_ctl (
    .clk(clk), .rst(rst), .dmode(dmode), .sdata(sdata), .sclk(sclk),
    .s_wr(s_wr), .e_wr(e_wr), .enh_n(enh_n),
    .dir_m(dir_m), .dir_r(dir_r), .dir_a(dir_a),
    .m_cnt(m_cnt), .r_cnt(r_cnt), .a_cnt(a_cnt), .pb_out(pb_out),
    .fp_en(fp_en), .pwr_dn(pwr_dn), .cnt_load(cnt_load), .msel_en(msel_en),
    .fc_en(fc_en), .enh_bypass(enh_bypass)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic gap(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bit(input logic b);
    sdata = b; gap(3);
    sclk = 1'b1; gap(3);
    sclk = 1'b0; gap(3);
  endtask

  task automatic send_word(input logic [19:0] w);
    for (int i = 19; i >= 0; i--) send_bit(w[i]);
  endtask

  task automatic pulse_swr;
    s_wr = 1'b1; gap(6);
    s_wr = 1'b0; gap(8);
  endtask

  task automatic write_enh(input logic [7:0] e);
    e_wr = 1'b1; gap(3);
    for (int i = 7; i >= 0; i--) send_bit(e[i]);
    e_wr = 1'b0; gap(8);
  endtask

  // Word layout from R2, first-sent bit at index 19.
  function automatic logic [19:0] pack_f(input logic [8:0] m, input logic [5:0] r,
                                         input logic [3:0] a, input logic pb);
    return {r[5], r[4], m[8], m[7], pb, m[6:0], r[3:0], a};
  endfunction

  function automatic logic [19:0] exp_of_word(input logic [19:0] w);
    logic [8:0] m; logic [5:0] r;
    m = {w[17], w[16], w[14:8]};
    r = {w[19], w[18], w[7:4]};
    return {m, r, w[3:0], w[15]};
  endfunction

  // Auxiliary mapping from R4 and R5, result order {bypass,fc,msel,load,pd,fp}.
  function automatic logic [5:0] exp_enh(input logic [7:0] e, input logic en_n);
    if (en_n) return 6'd0;
    return {e[1], e[2], e[3], e[4], e[5], e[6]};
  endfunction

  function automatic logic [19:0] act_f();
    return {m_cnt, r_cnt, a_cnt, pb_out};
  endfunction

  function automatic logic [5:0] act_e();
    return {enh_bypass, fc_en, msel_en, cnt_load, pwr_dn, fp_en};
  endfunction

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin : stim
    logic [19:0] w, held;
    logic [7:0]  e, last_e;
    gap(5);
    rst = 1'b0;
    gap(2);
    chk("R1 freq after reset", act_f(), 0);
    chk("R1 aux after reset", act_e(), 0);

    // R2 arithmetic sweep over swallow values
    for (int a = 0; a < 16; a++) begin
      w = pack_f(9'((a * 37 + 5) % 512), 6'((a * 11 + 3) % 64), 4'(a), a[0]);
      send_word(w); pulse_swr();
      chk("R2 sweep", act_f(), {9'((a * 37 + 5) % 512), 6'((a * 11 + 3) % 64), 4'(a), a[0]});
    end

    // R2 walking one over the field layout
    for (int k = 0; k < 20; k++) begin
      w = 20'd1 << k;
      send_word(w); pulse_swr();
      chk("R2 walking one", act_f(), exp_of_word(w));
    end
    held = 20'd1 << 19;

    // R3 frequency strobe while auxiliary strobe high
    e_wr = 1'b1; gap(3);
    w = 20'h5A3C6;
    send_word(w);
    s_wr = 1'b1; gap(6); s_wr = 1'b0; gap(6);
    e_wr = 1'b0; gap(8);
    chk("R3 freq unchanged", act_f(), exp_of_word(held));
    chk("R6 aux takes last 8 of 20", act_e(), exp_enh(w[7:0], 1'b0));

    // R4 and R5 exhaustive auxiliary sweep
    for (int v = 0; v < 256; v++) begin
      e = 8'(v);
      write_enh(e);
      chk("R4 aux byte", act_e(), exp_enh(e, 1'b0));
      if (v % 32 == 7) begin
        enh_n = 1'b1; gap(3);
        chk("R5 aux masked", act_e(), exp_enh(e, 1'b1));
        enh_n = 1'b0; gap(3);
        chk("R5 aux restored", act_e(), exp_enh(e, 1'b0));
      end
    end
    last_e = 8'hFF;
    chk("R4 freq kept through aux writes", act_f(), exp_of_word(held));

    // R6 over-length frequency stream
    for (int i = 0; i < 5; i++) send_bit(1'b1);
    w = pack_f(9'h0A5, 6'h12, 4'h9, 1'b0);
    send_word(w); pulse_swr();
    chk("R6 last 20 bits", act_f(), exp_of_word(w));

    // R6 over-length auxiliary stream
    e_wr = 1'b1; gap(3);
    for (int i = 0; i < 4; i++) send_bit(1'b1);
    e = 8'b1000_0001;
    for (int i = 7; i >= 0; i--) send_bit(e[i]);
    e_wr = 1'b0; gap(8);
    chk("R6 last 8 bits", act_e(), exp_enh(e, 1'b0));
    last_e = e;

    // R9 data glitches with steady serial clock
    w = pack_f(9'h133, 6'h2D, 4'h6, 1'b1);
    for (int i = 19; i >= 1; i--) send_bit(w[i]);
    for (int t = 0; t < 6; t++) begin
      sdata = ~sdata; gap(3);
    end
    send_bit(w[0]); pulse_swr();
    chk("R9 no shift without clock", act_f(), exp_of_word(w));
    held = w;

    // R7 direct mode sweep
    dmode = 1'b1;
    for (int i = 0; i < 32; i++) begin
      dir_m = 9'((i * 53 + 7) % 512);
      dir_r = 6'((i * 29 + 1) % 64);
      dir_a = 4'((i * 5) % 16);
      gap(3);
      chk("R7 direct fields", act_f(),
          {9'((i * 53 + 7) % 512), 6'((i * 29 + 1) % 64), 4'((i * 5) % 16), 1'b0});
    end

    // R8 strobe ignored in direct mode
    send_word(pack_f(9'h1FF, 6'h3F, 4'hF, 1'b1));
    pulse_swr();
    chk("R8 direct still on pins", act_f(), {dir_m, dir_r, dir_a, 1'b0});
    dmode = 1'b0; gap(3);
    chk("R8 serial word preserved", act_f(), exp_of_word(held));
    chk("R4 aux unchanged at end", act_e(), exp_enh(last_e, 1'b0));

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule